// File: doc/BRIEF.md
# Dual-channel serial byte shifter

This block feeds bytes to a host over two serial data lines. A single 8-bit parallel bus is shared by both lines. A load strobe, together with a channel select, copies the bus into one of two shift registers. The other register is left unchanged. Each register then presents its most significant bit on its serial line.

The host's shift clock is slow, and the block is not clocked by it. One register, clocked by the fast system clock, samples it. Only that sampled copy is used inside the block. A falling edge of the sampled copy advances both registers by one bit, with zeros filling in from the bottom. The same sampled copy is echoed on two clock output pins.

An end-of-frame input controls whether the outputs are driven. While it is high, the block drives both serial lines, both clock echoes and a done line that is held low. While it is low, all of these outputs float. Each output is modelled as a value plus an output-enable, so no bidirectional pins are needed.

Top module: `dual_byte_shifter`

## Requirements
- R1: A synchronous active-high reset clears both channel registers and the sampled shift clock. After reset, `ser_a`, `ser_b`, `clk_echo_a` and `clk_echo_b` are all 0.
- R2: When `load` is 1 and `chan_sel` is 1 at a rising edge of `clk`, channel A takes `din`. `ser_a` then shows `din[7]` after that edge, and channel B keeps its contents.
- R3: When `load` is 1 and `chan_sel` is 0 at a rising edge of `clk`, channel B takes `din`. Channel A keeps its contents, and at most one channel is loaded in any cycle.
- R4: Each shift sends the byte out most significant bit first: after k shifts, the serial output shows bit 7-k of the loaded byte. Zeros are fed into bit 0, so after 8 shifts the output reads 0.
- R5: A shift happens only on a 1-to-0 transition of the sampled shift clock, and it advances both channels together. A rising transition, or a level held steady, leaves both outputs unchanged.
- R6: The shift clock is registered once on `clk`. A change of `shift_clk_in` appears on `clk_echo_a` and `clk_echo_b` after exactly one rising edge of `clk`.
- R7: Every `*_oe` output equals `eof_en`: the outputs are driven while it is 1 and floating while it is 0.
- R8: `done` is 0 whenever `done_oe` is 1.
- R9: If a load and a shift edge fall in the same `clk` cycle, the load wins. The selected channel then holds the new byte, unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| eof_en | input | 1 | End-of-frame; output enable for all outputs |
| load | input | 1 | Parallel load strobe |
| chan_sel | input | 1 | 1 steers the load to channel A, 0 to channel B |
| din | input | 8 | Parallel byte bus |
| shift_clk_in | input | 1 | Slow external shift clock |
| ser_a | output | 1 | Channel A serial data |
| ser_a_oe | output | 1 | Drive enable for ser_a |
| ser_b | output | 1 | Channel B serial data |
| ser_b_oe | output | 1 | Drive enable for ser_b |
| clk_echo_a | output | 1 | Sampled shift clock, first copy |
| clk_echo_a_oe | output | 1 | Drive enable for clk_echo_a |
| clk_echo_b | output | 1 | Sampled shift clock, second copy |
| clk_echo_b_oe | output | 1 | Drive enable for clk_echo_b |
| done | output | 1 | Done line, always 0 |
| done_oe | output | 1 | Drive enable for done |

## Verification
A channel register holding wrong state shows up on its serial line. A bad load is visible in the cycle right after the load edge. A bad shift or fill bit is visible one shift later, and any fill error shows in the all-zero value after the eighth shift. A wrong edge detector appears in three ways: a shift on a rising edge, a missing shift, or an extra shift. Each of these becomes visible about two fast cycles after the host clock changes. A wrong clock sample shows on the clock echoes one cycle after the input changes.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  typedef struct packed {
    logic to_a;
    logic to_b;
  } dsh_steer_t;

  // Both lane strobes come from the same expression stage, so neither one lags the other.
  function automatic dsh_steer_t dsh_steer(input logic ld, input logic sel);
    dsh_steer_t s;
    s.to_a = ld & sel;
    s.to_b = ld & ~sel;
    return s;
  endfunction
endpackage

// File: rtl/dsh_clk_sampler.sv
module dsh_clk_sampler (
  input  logic clk,
  input  logic rst,
  input  logic raw_clk,
  output logic smp_clk,
  output logic fall_evt
);
  logic smp_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_clk  <= 1'b0;
      smp_prev <= 1'b0;
    end else begin
      smp_clk  <= raw_clk;
      smp_prev <= smp_clk;
    end
  end

  assign fall_evt = smp_prev & ~smp_clk;

  AST_SAMPLE_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> smp_clk == $past(raw_clk)); // R6
endmodule

// File: rtl/dsh_channel.sv
module dsh_channel #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             ser
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] v);
    return {v[MSB-1:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= din;
    else if (adv) q <= advance(q);
  end

  assign ser = q[MSB];

  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(din)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv) |=> $stable(q)); // R5
endmodule

// File: rtl/dual_byte_shifter.sv
module dual_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eof_en,
  input  logic              load,
  input  logic              chan_sel,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift_clk_in,
  output logic              ser_a,
  output logic              ser_a_oe,
  output logic              ser_b,
  output logic              ser_b_oe,
  output logic              clk_echo_a,
  output logic              clk_echo_a_oe,
  output logic              clk_echo_b,
  output logic              clk_echo_b_oe,
  output logic              done,
  output logic              done_oe
);
  import dsh_pkg::*;

  logic        smp_clk;
  logic        fall_evt;
  dsh_steer_t  steer;
  logic [BYTE_W-1:0] q_a, q_b;

  assign steer = dsh_steer(load, chan_sel);

  dsh_clk_sampler u_smp (
    .clk(clk), .rst(rst), .raw_clk(shift_clk_in),
    .smp_clk(smp_clk), .fall_evt(fall_evt)
  );

  dsh_channel #(.WIDTH(BYTE_W)) u_ch_a (
    .clk(clk), .rst(rst), .ld(steer.to_a), .adv(fall_evt),
    .din(din), .q(q_a), .ser(ser_a)
  );

  dsh_channel #(.WIDTH(BYTE_W)) u_ch_b (
    .clk(clk), .rst(rst), .ld(steer.to_b), .adv(fall_evt),
    .din(din), .q(q_b), .ser(ser_b)
  );

  assign clk_echo_a    = smp_clk;
  assign clk_echo_b    = smp_clk;
  assign done          = 1'b0;
  assign ser_a_oe      = eof_en;
  assign ser_b_oe      = eof_en;
  assign clk_echo_a_oe = eof_en;
  assign clk_echo_b_oe = eof_en;
  assign done_oe       = eof_en;

  AST_ONE_LANE_LOADS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({steer.to_a, steer.to_b})); // R3
  AST_B_KEPT_ON_A_LOAD: assert property (@(posedge clk) disable iff (rst)
    (steer.to_a && !fall_evt) |=> $stable(q_b)); // R2
  AST_A_KEPT_ON_B_LOAD: assert property (@(posedge clk) disable iff (rst)
    (steer.to_b && !fall_evt) |=> $stable(q_a)); // R3
  AST_ECHO_PAIR_MATCH: assert property (@(posedge clk) disable iff (rst)
    clk_echo_a == clk_echo_b); // R6
endmodule

// File: tb/test_dual_byte_shifter.sv
module test_dual_byte_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eof_en = 1'b1;
  logic load = 1'b0;
  logic chan_sel = 1'b0;
  logic [7:0] din = 8'h00;
  logic shift_clk_in = 1'b0;
  logic ser_a, ser_a_oe, ser_b, ser_b_oe;
  logic clk_echo_a, clk_echo_a_oe, clk_echo_b, clk_echo_b_oe;
  logic done, done_oe;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_byte_shifter i_dual_byte_shifter (
    .clk(clk), .rst(rst), .eof_en(eof_en), .load(load), .chan_sel(chan_sel),
    .din(din), .shift_clk_in(shift_clk_in),
    .ser_a(ser_a), .ser_a_oe(ser_a_oe), .ser_b(ser_b), .ser_b_oe(ser_b_oe),
    .clk_echo_a(clk_echo_a), .clk_echo_a_oe(clk_echo_a_oe),
    .clk_echo_b(clk_echo_b), .clk_echo_b_oe(clk_echo_b_oe),
    .done(done), .done_oe(done_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_byte(input logic s, input logic [7:0] d);
    chan_sel = s; din = d; load = 1'b1;
    step();
    load = 1'b0; din = 8'h00;
    step();
  endtask

  task automatic pulse();
    shift_clk_in = 1'b1;
    repeat (3) step();
    shift_clk_in = 1'b0;
    repeat (3) step();
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) step(); rst = 1'b0; step();
    chk("R1 ser_a", {7'd0, ser_a}, 8'd0);
    chk("R1 ser_b", {7'd0, ser_b}, 8'd0);
    chk("R1 echo", {6'd0, clk_echo_a, clk_echo_b}, 8'd0);
  endtask

  task automatic t_load_steer();
    load_byte(1'b1, 8'h80);
    chk("R2 ser_a msb", {7'd0, ser_a}, 8'd1);
    chk("R2 ser_b kept", {7'd0, ser_b}, 8'd0);
    load_byte(1'b0, 8'hC0);
    chk("R3 ser_b msb", {7'd0, ser_b}, 8'd1);
    chk("R3 ser_a kept", {7'd0, ser_a}, 8'd1);
  endtask

  task automatic t_shift_order(input logic [7:0] a_val, input logic [7:0] b_val);
    logic [7:0] ea, eb;
    load_byte(1'b1, a_val);
    load_byte(1'b0, b_val);
    ea = a_val; eb = b_val;
    for (int k = 0; k < 8; k++) begin
      chk("R4 ser_a bit", {7'd0, ser_a}, {7'd0, ea[7]});
      chk("R5 ser_b bit", {7'd0, ser_b}, {7'd0, eb[7]});
      pulse();
      ea = (ea << 1) & 8'hFF;
      eb = (eb << 1) & 8'hFF;
    end
    chk("R4 zero fill a", {7'd0, ser_a}, 8'd0);
    chk("R4 zero fill b", {7'd0, ser_b}, 8'd0);
  endtask

  task automatic t_edge_polarity();
    load_byte(1'b1, 8'hA0);
    shift_clk_in = 1'b1;
    repeat (4) step();
    chk("R5 rise no shift", {7'd0, ser_a}, 8'd1);
    shift_clk_in = 1'b0;
    step();
    chk("R5 before fall seen", {7'd0, ser_a}, 8'd1);
    step();
    chk("R5 shifted on fall", {7'd0, ser_a}, 8'd0);
    repeat (4) step();
    chk("R5 low level holds", {7'd0, ser_a}, 8'd0);
  endtask

  task automatic t_echo();
    shift_clk_in = 1'b1;
    #1;
    chk("R6 not combinational", {7'd0, clk_echo_a}, 8'd0);
    step();
    chk("R6 echo a one edge", {7'd0, clk_echo_a}, 8'd1);
    chk("R6 echo b one edge", {7'd0, clk_echo_b}, 8'd1);
    shift_clk_in = 1'b0;
    step();
    chk("R6 echo falls", {6'd0, clk_echo_a, clk_echo_b}, 8'd0);
    repeat (3) step();
  endtask

  task automatic t_enables();
    eof_en = 1'b0; #1;
    chk("R7 oe off", {3'd0, ser_a_oe, ser_b_oe, clk_echo_a_oe, clk_echo_b_oe, done_oe}, 8'h00);
    eof_en = 1'b1; #1;
    chk("R7 oe on", {3'd0, ser_a_oe, ser_b_oe, clk_echo_a_oe, clk_echo_b_oe, done_oe}, 8'h1F);
    chk("R8 done low", {7'd0, done}, 8'd0);
    step();
  endtask

  task automatic t_load_priority();
    shift_clk_in = 1'b1;
    repeat (3) step();
    shift_clk_in = 1'b0;
    step();
    chan_sel = 1'b1; din = 8'hA5; load = 1'b1;
    step();
    load = 1'b0; din = 8'h00;
    step();
    chk("R9 load wins bit7", {7'd0, ser_a}, 8'd1);
    pulse();
    chk("R9 next bit6", {7'd0, ser_a}, 8'd0);
    pulse();
    chk("R9 next bit5", {7'd0, ser_a}, 8'd1);
  endtask

  initial begin
    t_reset();
    t_load_steer();
    t_shift_order(8'hB6, 8'h4D);
    t_shift_order(8'hFF, 8'h01);
    t_edge_polarity();
    t_echo();
    t_enables();
    t_load_priority();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule